// File: doc/BRIEF.md
# Interleaved IQ Transmit Word Pairer

This block sits at the baseband edge of a transmit path. A single 12-bit bus carries I and Q words in turn, one word per rising edge of an interface clock that runs at twice the converter sample rate. A frame-select line marks which word opens each two-word frame. The block registers every word and the select line. When it sees the closing word of a frame, it joins that word with the opening word into one complex sample and presents it on separate I and Q outputs with a one-cycle valid pulse.

A converter sample strobe comes from the registered copy of the frame-select line, not from a clock divider. If the select line stops alternating, the block produces neither samples nor strobes. Three configuration inputs set how frames are read. The first sets which level of frame-select marks the opening word. The second sets whether I or Q travels first. The third sets whether the strobe fires at the start or at the end of a frame.

Top module: `iq_tx_deinterleave`

## Requirements
- R1: While `rst_n` is low and after it is released, `pair_valid`, `pair_i`, `pair_q` and `conv_strobe` are all 0 until a frame is taken.
- R2: With `cfg_q_first` = 0, `pair_i` carries the opening word and `pair_q` the closing word of a frame. Both appear with `pair_valid` = 1 in the clock cycle that follows the rising edge that captured the closing word.
- R3: With `cfg_q_first` = 1, the order is reversed: the opening word goes to `pair_q` and the closing word to `pair_i`.
- R4: With `cfg_sel_low_first` = 0, `frame_sel` = 1 marks the opening word and 0 marks the closing word. With `cfg_sel_low_first` = 1, `frame_sel` = 0 marks the opening word and 1 marks the closing word.
- R5: A closing word is paired only when the word captured just before it was an opening word. While `frame_sel` holds one level, `pair_valid` and `conv_strobe` stay 0.
- R6: With `cfg_strobe_at_end` = 0, `conv_strobe` is high for exactly one cycle: the cycle after the edge that captured an opening word that follows a closing word.
- R7: With `cfg_strobe_at_end` = 1, `conv_strobe` is high for exactly one cycle: the cycle after the edge that captured a closing word that follows an opening word. This is the same cycle as `pair_valid`.
- R8: `pair_valid` is never high in two consecutive cycles. `pair_i` and `pair_q` keep their value in every cycle in which `pair_valid` is low.
- R9: Words are 12-bit two's complement and pass bit-exact, including the extremes 0x7FF and 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all capture on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_word | input | 12 | Interleaved I/Q word bus |
| frame_sel | input | 1 | Marks the opening or the closing word of a frame |
| cfg_sel_low_first | input | 1 | 0: high select opens a frame; 1: low select opens a frame |
| cfg_q_first | input | 1 | 0: I is the opening word; 1: Q is the opening word |
| cfg_strobe_at_end | input | 1 | 0: strobe at frame start; 1: strobe at frame end |
| pair_i | output | 12 | I part of the last complete frame |
| pair_q | output | 12 | Q part of the last complete frame |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |
| conv_strobe | output | 1 | Converter sample strobe |

## Verification
Every result is due a fixed number of register stages after its stimulus. The pair and its valid pulse appear in the cycle after the edge that took the closing word. A start-of-frame strobe appears in the cycle after the edge that took the opening word. An end-of-frame strobe coincides with the valid pulse. The bench drives inputs on the falling edge and samples outputs on the following falling edge, just before it drives the next word. This places every check exactly one register stage after the edge it depends on. Stuck-select cases are checked on every cycle of the hold, so a late or early pulse cannot go unseen.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;
   localparam int unsigned DEF_WORD_W = 12;
   localparam int unsigned LANES      = 2;

   typedef enum logic {
      LANE_I = 1'b0,
      LANE_Q = 1'b1
   } lane_e;

   typedef enum logic {
      STROBE_AT_START = 1'b0,
      STROBE_AT_END   = 1'b1
   } strobe_edge_e;
endpackage

// File: rtl/iq_word_capture.sv
module iq_word_capture #(
   parameter int unsigned WORD_W = iq_deint_pkg::DEF_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_in,
   input  logic              frame_sel,
   input  logic              sel_low_first,
   output logic              open_now,
   output logic              open_q,
   output logic              open_qq,
   output logic [WORD_W-1:0] word_q
);
   // normalized phase: 1 = opening word of a frame
   assign open_now = frame_sel ^ sel_low_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         open_q  <= 1'b0;
         open_qq <= 1'b0;
      end else begin
         word_q  <= word_in;
         open_q  <= open_now;
         open_qq <= open_q;
      end
   end
endmodule

// File: rtl/iq_frame_pair.sv
module iq_frame_pair #(
   parameter int unsigned WORD_W = iq_deint_pkg::DEF_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_now,
   input  logic              open_q,
   input  logic [WORD_W-1:0] first_word,
   input  logic [WORD_W-1:0] second_word,
   input  logic              q_first,
   output logic [WORD_W-1:0] out_i,
   output logic [WORD_W-1:0] out_q,
   output logic              out_valid
);
   localparam int unsigned LANES = iq_deint_pkg::LANES;

   logic                           close_hit;
   logic [LANES-1:0][WORD_W-1:0]   src;
   logic [LANES-1:0][WORD_W-1:0]   lane_d;
   logic [LANES-1:0][WORD_W-1:0]   lane_r;

   assign close_hit = open_q & ~open_now;
   assign src[0]    = first_word;
   assign src[1]    = second_word;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // lane 0 is I, lane 1 is Q; order flag swaps the source
      assign lane_d[g] = q_first ? src[LANES-1-g] : src[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         lane_r[g] <= '0;
         else if (close_hit) lane_r[g] <= lane_d[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= close_hit;
   end

   assign out_i = lane_r[iq_deint_pkg::LANE_I];
   assign out_q = lane_r[iq_deint_pkg::LANE_Q];
endmodule

// File: rtl/iq_strobe_gen.sv
module iq_strobe_gen (
   input  logic open_q,
   input  logic open_qq,
   input  logic at_end,
   output logic strobe
);
   logic start_edge;
   logic end_edge;

   // transitions of the registered select copy, never a clock divider
   assign start_edge = open_q & ~open_qq;
   assign end_edge   = ~open_q & open_qq;
   assign strobe     = (at_end == iq_deint_pkg::STROBE_AT_END) ? end_edge : start_edge;
endmodule

// File: rtl/iq_tx_deinterleave.sv
module iq_tx_deinterleave #(
   parameter int unsigned WORD_W = iq_deint_pkg::DEF_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              frame_sel,
   input  logic              cfg_sel_low_first,
   input  logic              cfg_q_first,
   input  logic              cfg_strobe_at_end,
   output logic [WORD_W-1:0] pair_i,
   output logic [WORD_W-1:0] pair_q,
   output logic              pair_valid,
   output logic              conv_strobe
);
   if (WORD_W < 2) begin : g_bad_width
      $error("iq_tx_deinterleave: WORD_W must be at least 2");
   end

   logic              open_now;
   logic              open_q;
   logic              open_qq;
   logic [WORD_W-1:0] word_q;

   iq_word_capture #(.WORD_W(WORD_W)) i_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .word_in       (tx_word),
      .frame_sel     (frame_sel),
      .sel_low_first (cfg_sel_low_first),
      .open_now      (open_now),
      .open_q        (open_q),
      .open_qq       (open_qq),
      .word_q        (word_q)
   );

   iq_frame_pair #(.WORD_W(WORD_W)) i_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .open_now    (open_now),
      .open_q      (open_q),
      .first_word  (word_q),
      .second_word (tx_word),
      .q_first     (cfg_q_first),
      .out_i       (pair_i),
      .out_q       (pair_q),
      .out_valid   (pair_valid)
   );

   iq_strobe_gen i_strobe (
      .open_q  (open_q),
      .open_qq (open_qq),
      .at_end  (cfg_strobe_at_end),
      .strobe  (conv_strobe)
   );
endmodule

// File: rtl/iq_tx_deinterleave_chk.sv
module iq_tx_deinterleave_chk #(
   parameter int unsigned WORD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] tx_word,
   input logic              frame_sel,
   input logic              cfg_sel_low_first,
   input logic              cfg_q_first,
   input logic              cfg_strobe_at_end,
   input logic [WORD_W-1:0] pair_i,
   input logic [WORD_W-1:0] pair_q,
   input logic              pair_valid,
   input logic              conv_strobe
);
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !pair_valid && !conv_strobe); // R1

   AST_CLOSE_TO_Q: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid && !$past(cfg_q_first) |-> pair_q == $past(tx_word)); // R2

   AST_CLOSE_TO_I: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid && $past(cfg_q_first) |-> pair_i == $past(tx_word)); // R3

   AST_CLOSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> ($past(frame_sel) ^ $past(cfg_sel_low_first)) == 1'b0); // R4

   AST_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> $past(frame_sel ^ cfg_sel_low_first, 2) == 1'b1); // R5

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_strobe |=> !conv_strobe); // R6

   AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_strobe_at_end && $stable(cfg_strobe_at_end) |-> conv_strobe == pair_valid); // R7

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid); // R8

   AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_valid |-> $stable(pair_i) && $stable(pair_q)); // R8
endmodule

bind iq_tx_deinterleave iq_tx_deinterleave_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_iq_tx_deinterleave.sv
module test_iq_tx_deinterleave;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic         frame_sel = 1'b0;
   logic         cfg_sel_low_first = 1'b0;
   logic         cfg_q_first = 1'b0;
   logic         cfg_strobe_at_end = 1'b0;
   logic [W-1:0] pair_i, pair_q;
   logic         pair_valid, conv_strobe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   iq_tx_deinterleave #(.WORD_W(W)) i_iq_tx_deinterleave (
      .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .frame_sel(frame_sel),
      .cfg_sel_low_first(cfg_sel_low_first), .cfg_q_first(cfg_q_first),
      .cfg_strobe_at_end(cfg_strobe_at_end), .pair_i(pair_i), .pair_q(pair_q),
      .pair_valid(pair_valid), .conv_strobe(conv_strobe)
   );

   // {sel_low_first, q_first, opening word, closing word, expected I, expected Q}
   localparam int NV = 8;
   localparam logic [49:0] VEC [NV] = '{
      {1'b0, 1'b0, 12'h123, 12'h456, 12'h123, 12'h456},
      {1'b0, 1'b1, 12'h123, 12'h456, 12'h456, 12'h123},
      {1'b1, 1'b0, 12'h7FF, 12'h800, 12'h7FF, 12'h800},
      {1'b1, 1'b1, 12'h800, 12'h7FF, 12'h7FF, 12'h800},
      {1'b0, 1'b0, 12'h000, 12'hFFF, 12'h000, 12'hFFF},
      {1'b1, 1'b0, 12'hA5A, 12'h5A5, 12'hA5A, 12'h5A5},
      {1'b0, 1'b1, 12'h001, 12'hFFE, 12'hFFE, 12'h001},
      {1'b1, 1'b1, 12'h3C3, 12'hC3C, 12'hC3C, 12'h3C3}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // drive one word with its normalized phase (1 = opening word)
   task automatic drive(input logic [W-1:0] w, input logic opening);
      tx_word   = w;
      frame_sel = opening ^ cfg_sel_low_first;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      check("R1 valid in reset", pair_valid, 0);
      check("R1 strobe in reset", conv_strobe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", pair_valid, 0);
      check("R1 I after reset", pair_i, 0);
      check("R1 Q after reset", pair_q, 0);
      check("R1 strobe after reset", conv_strobe, 0);

      // table walk: R2, R3, R4, R9, strobe at start R6
      for (int v = 0; v < NV; v++) begin
         cfg_sel_low_first = VEC[v][49];
         cfg_q_first       = VEC[v][48];
         drive(VEC[v][47:36], 1'b1);
         check("R6 strobe after opening word", conv_strobe, 1);
         check("R5 no valid after opening word", pair_valid, 0);
         drive(VEC[v][35:24], 1'b0);
         check("R2 R3 R4 valid after closing word", pair_valid, 1);
         check("R2 R3 R9 I value", pair_i, VEC[v][23:12]);
         check("R2 R3 R9 Q value", pair_q, VEC[v][11:0]);
         check("R6 no strobe at frame end", conv_strobe, 0);
      end

      // R5, R8: select stuck at closing level, then at opening level
      cfg_sel_low_first = 1'b0;
      cfg_q_first       = 1'b0;
      for (int k = 0; k < 4; k++) begin
         drive(12'h111 + 12'(k), 1'b0);
         check("R5 stuck closing: no valid", pair_valid, 0);
         check("R5 stuck closing: no strobe", conv_strobe, 0);
         check("R8 I held", pair_i, 12'hC3C);
      end
      drive(12'h222, 1'b1);
      check("R6 strobe on first opening", conv_strobe, 1);
      for (int k = 0; k < 3; k++) begin
         drive(12'h333 + 12'(k), 1'b1);
         check("R5 stuck opening: no valid", pair_valid, 0);
         check("R5 stuck opening: no strobe", conv_strobe, 0);
         check("R8 Q held", pair_q, 12'h3C3);
      end
      // latest opening word pairs with the closing word
      drive(12'h444, 1'b0);
      check("R5 pair after stuck run valid", pair_valid, 1);
      check("R5 pair uses latest opening word", pair_i, 12'h335);
      check("R8 single-cycle valid setup", pair_q, 12'h444);
      drive(12'h555, 1'b0);
      check("R8 valid drops", pair_valid, 0);

      // R7: strobe at frame end
      cfg_strobe_at_end = 1'b1;
      drive(12'h0AB, 1'b1);
      check("R7 no strobe after opening", conv_strobe, 0);
      drive(12'h0CD, 1'b0);
      check("R7 strobe with valid", conv_strobe, 1);
      check("R7 valid", pair_valid, 1);
      drive(12'h0EF, 1'b1);
      check("R7 strobe single cycle", conv_strobe, 0);

      // R1: reset mid-stream clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 I cleared", pair_i, 0);
      check("R1 Q cleared", pair_q, 0);
      check("R1 valid cleared", pair_valid, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule